// File: doc/BRIEF.md
# Operand Address Generator

This block forms the 16-bit operand address for a small 8-bit accumulator processor. For each request it takes the addressing mode, up to two operand bytes, the two index registers, the program counter, a flag that makes the page-crossing penalty apply, and the branch outcome. It returns the effective address together with the number of extra cycles the access costs.

Zero-page, absolute and branch modes need no memory access, and they finish one cycle after the request. The two indirect modes read a two-byte pointer from memory through a simple read port with a fixed one-cycle latency. The block reports `busy` while it fetches and ignores new requests until the fetch ends. It only computes addresses. It does not decode opcodes, does no arithmetic on data and never writes memory.

Top module: `addr_gen_top`

## Requirements
- R1: `mode` encoding: 0 zero page, 1 zero page + X, 2 zero page + Y, 3 absolute, 4 absolute + X, 5 absolute + Y, 6 indirect pre-indexed by X, 7 indirect post-indexed by Y, 8 relative branch. Modes 0 to 2 give `ea` = {8'h00, (op_lo + index) mod 256}, with no index for mode 0, so the high byte is always zero.
- R2: Absolute modes give `ea` = {op_hi, op_lo}. Modes 4 and 5 add X or Y to it modulo 65536.
- R3: For modes 4, 5 and 7, `extra_cyc` is 1 when `pen_ok` was high with the request and the indexed address has a different high byte from the base. In every other case it is 0.
- R4: Mode 6 reads the pointer at zero-page address (op_lo + X) mod 256, and `ea` is that pointer. `extra_cyc` is 0.
- R5: Mode 7 reads the pointer at zero-page address op_lo, and `ea` = pointer + Y modulo 65536.
- R6: A pointer read puts the low byte at address A and the high byte at (A + 1) mod 65536. The two reads go out on consecutive cycles. A pointer at 8'hFF takes its high byte from 16'h0100.
- R7: In mode 8 with `br_taken` high, `ea` = pc + 1 + the sign-extended op_lo, where `pc` is the address of the offset byte. `extra_cyc` is 1, or 2 when the target's high byte differs from that of pc + 1.
- R8: In mode 8 with `br_taken` low, `ea` = pc + 1 and `extra_cyc` = 0.
- R9: A request is accepted when `start` is high and `busy` is low. For a direct mode, `done` pulses on the next cycle. For an indirect mode, `rd_req` is high on the two cycles after acceptance and `done` pulses three cycles after the first read was issued. A `start` while `busy` is high is ignored.
- R10: After reset, `done`, `busy`, `rd_req` and `extra_cyc` are 0 and `ea` is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| mode | input | 4 | Addressing mode (encoding in R1) |
| op_lo | input | 8 | First operand byte, or the branch offset |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Address of the branch offset byte |
| pen_ok | input | 1 | Page-crossing penalty applies to this request |
| br_taken | input | 1 | The branch condition holds |
| busy | output | 1 | Pointer fetch in progress |
| rd_req | output | 1 | Memory read strobe |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_req` |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| extra_cyc | output | 2 | Extra cycles from a page crossing or a taken branch |

## Verification
The assertions check properties on every cycle: a zero-page result never leaves page zero, a direct mode finishes on the next cycle, the two pointer reads go to consecutive addresses, no read happens while idle, and a not-taken branch returns pc + 1 with no penalty. Only the bench scenarios can show the actual address values and penalty counts. These include index wrap-around, a pointer at the top of page zero, backward branches that cross a page, the post-indexed penalty, and a request sent while busy that must produce no second result.

// File: rtl/addr_gen_pkg.sv
package addr_gen_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int XC_W   = 2;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_ZP   = 4'd0,
        AM_ZPX  = 4'd1,
        AM_ZPY  = 4'd2,
        AM_ABS  = 4'd3,
        AM_ABSX = 4'd4,
        AM_ABSY = 4'd5,
        AM_INDX = 4'd6,
        AM_INDY = 4'd7,
        AM_REL  = 4'd8
    } amode_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_LO,
        FS_HI,
        FS_LAST
    } fstate_e;

    function automatic logic is_indirect(input logic [MODE_W-1:0] m);
        return (m == AM_INDX) || (m == AM_INDY);
    endfunction

    function automatic logic page_differs(input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] b);
        return a[ADDR_W-1:DATA_W] != b[ADDR_W-1:DATA_W];
    endfunction
endpackage

// File: rtl/addr_gen_penalty.sv
module addr_gen_penalty
    import addr_gen_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] idx,
    input  logic              elig,
    output logic [ADDR_W-1:0] sum,
    output logic              pen
);
    localparam int PAD_W = ADDR_W - DATA_W;

    always_comb begin
        sum = base + {{PAD_W{1'b0}}, idx};
        pen = elig && page_differs(base, sum);
    end
endmodule

// File: rtl/addr_gen_direct.sv
module addr_gen_direct
    import addr_gen_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] op_lo,
    input  logic [DATA_W-1:0] op_hi,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic [ADDR_W-1:0] pc,
    input  logic              pen_ok,
    input  logic              br_taken,
    output logic [ADDR_W-1:0] ea,
    output logic [XC_W-1:0]   extra,
    output logic [ADDR_W-1:0] ptr_addr
);
    localparam int PAD_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] abs_base;
    logic [DATA_W-1:0] abs_idx;
    logic [ADDR_W-1:0] abs_sum;
    logic              abs_pen;
    logic [DATA_W-1:0] zp_x;
    logic [DATA_W-1:0] zp_y;
    logic [ADDR_W-1:0] br_base;
    logic [ADDR_W-1:0] br_tgt;

    assign abs_base = {op_hi, op_lo};
    assign abs_idx  = (mode == AM_ABSY) ? idx_y : idx_x;

    addr_gen_penalty u_abs_pen (
        .base (abs_base),
        .idx  (abs_idx),
        .elig (pen_ok),
        .sum  (abs_sum),
        .pen  (abs_pen)
    );

    always_comb begin
        zp_x    = op_lo + idx_x;
        zp_y    = op_lo + idx_y;
        br_base = pc + 16'd1;
        br_tgt  = br_base + {{PAD_W{op_lo[DATA_W-1]}}, op_lo};
        ptr_addr = {{PAD_W{1'b0}}, (mode == AM_INDX) ? zp_x : op_lo};
        ea    = abs_base;
        extra = '0;
        case (amode_e'(mode))
            AM_ZP:   ea = {{PAD_W{1'b0}}, op_lo};
            AM_ZPX:  ea = {{PAD_W{1'b0}}, zp_x};
            AM_ZPY:  ea = {{PAD_W{1'b0}}, zp_y};
            AM_ABS:  ea = abs_base;
            AM_ABSX, AM_ABSY: begin
                ea    = abs_sum;
                extra = {1'b0, abs_pen};
            end
            AM_REL: begin
                if (br_taken) begin
                    ea    = br_tgt;
                    extra = page_differs(br_base, br_tgt) ? 2'd2 : 2'd1;
                end else begin
                    ea = br_base;
                end
            end
            default: ea = abs_base;
        endcase
    end
endmodule

// File: rtl/addr_gen_fetch.sv
module addr_gen_fetch
    import addr_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] ptr_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] word,
    output logic              word_ok,
    output logic              busy
);
    fstate_e           st_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FS_IDLE;
            ptr_q <= '0;
            lo_q  <= '0;
        end else begin
            case (st_q)
                FS_IDLE: if (go) begin
                    st_q  <= FS_LO;
                    ptr_q <= ptr_addr;
                end
                FS_LO:   st_q <= FS_HI;
                FS_HI: begin
                    lo_q <= rd_data;
                    st_q <= FS_LAST;
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req  = (st_q == FS_LO) || (st_q == FS_HI);
        rd_addr = (st_q == FS_HI) ? ptr_q + 16'd1 : ptr_q;
        word    = {rd_data, lo_q};
        word_ok = (st_q == FS_LAST);
        busy    = (st_q != FS_IDLE);
    end
endmodule

// File: rtl/addr_gen_top.sv
module addr_gen_top
    import addr_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  mode,
    input  logic [7:0]  op_lo,
    input  logic [7:0]  op_hi,
    input  logic [7:0]  idx_x,
    input  logic [7:0]  idx_y,
    input  logic [15:0] pc,
    input  logic        pen_ok,
    input  logic        br_taken,
    output logic        busy,
    output logic        rd_req,
    output logic [15:0] rd_addr,
    input  logic [7:0]  rd_data,
    output logic        done,
    output logic [15:0] ea,
    output logic [1:0]  extra_cyc
);
    logic              accept;
    logic [ADDR_W-1:0] dir_ea;
    logic [XC_W-1:0]   dir_extra;
    logic [ADDR_W-1:0] ptr_addr;
    logic [ADDR_W-1:0] word;
    logic              word_ok;
    logic [ADDR_W-1:0] post_sum;
    logic              post_pen;
    logic [MODE_W-1:0] mode_q;
    logic [DATA_W-1:0] y_q;
    logic              pen_q;

    assign accept = start && !busy;

    addr_gen_direct u_direct (
        .mode     (mode),
        .op_lo    (op_lo),
        .op_hi    (op_hi),
        .idx_x    (idx_x),
        .idx_y    (idx_y),
        .pc       (pc),
        .pen_ok   (pen_ok),
        .br_taken (br_taken),
        .ea       (dir_ea),
        .extra    (dir_extra),
        .ptr_addr (ptr_addr)
    );

    addr_gen_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .go       (accept && is_indirect(mode)),
        .ptr_addr (ptr_addr),
        .rd_data  (rd_data),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .word     (word),
        .word_ok  (word_ok),
        .busy     (busy)
    );

    addr_gen_penalty u_post_pen (
        .base (word),
        .idx  (y_q),
        .elig (pen_q),
        .sum  (post_sum),
        .pen  (post_pen)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            ea        <= '0;
            extra_cyc <= '0;
            mode_q    <= '0;
            y_q       <= '0;
            pen_q     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                mode_q <= mode;
                y_q    <= idx_y;
                pen_q  <= pen_ok;
                if (!is_indirect(mode)) begin
                    done      <= 1'b1;
                    ea        <= dir_ea;
                    extra_cyc <= dir_extra;
                end
            end
            if (word_ok) begin
                done <= 1'b1;
                if (mode_q == AM_INDY) begin
                    ea        <= post_sum;
                    extra_cyc <= {1'b0, post_pen};
                end else begin
                    ea        <= word;
                    extra_cyc <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [3:0]  mode,
    input logic [15:0] pc,
    input logic        pen_ok,
    input logic        br_taken,
    input logic        busy,
    input logic        rd_req,
    input logic [15:0] rd_addr,
    input logic        done,
    input logic [15:0] ea,
    input logic [1:0]  extra_cyc
);
    logic acc;
    assign acc = start && !busy;

    assert_zp_page_R1: assert property (@(posedge clk) disable iff (rst)
        acc && (mode <= 4'd2) |=> done && (ea[15:8] == 8'h00));

    assert_direct_lat_R9: assert property (@(posedge clk) disable iff (rst)
        acc && ((mode <= 4'd5) || (mode == 4'd8)) |=> done && !busy);

    assert_ptr_pair_R6: assert property (@(posedge clk) disable iff (rst)
        rd_req && $past(rd_req) |-> rd_addr == $past(rd_addr) + 16'd1);

    assert_idle_noread_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req);

    assert_pen_off_R3: assert property (@(posedge clk) disable iff (rst)
        acc && ((mode == 4'd4) || (mode == 4'd5)) && !pen_ok |=> extra_cyc == 2'd0);

    assert_not_taken_R8: assert property (@(posedge clk) disable iff (rst)
        acc && (mode == 4'd8) && !br_taken |=>
            done && (extra_cyc == 2'd0) && (ea == $past(pc) + 16'd1));

    assert_extra_range_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> extra_cyc != 2'd3);
endmodule

bind addr_gen_top addr_gen_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode      (mode),
    .pc        (pc),
    .pen_ok    (pen_ok),
    .br_taken  (br_taken),
    .busy      (busy),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .done      (done),
    .ea        (ea),
    .extra_cyc (extra_cyc)
);

// File: tb/addr_gen_top_tb_top.sv
module addr_gen_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
    logic [15:0] pc = '0;
    logic        pen_ok = 1'b0, br_taken = 1'b0;
    logic        busy, rd_req, done;
    logic [15:0] rd_addr, ea;
    logic [7:0]  rd_data = '0;
    logic [1:0]  extra_cyc;

    int total = 0;
    int bad = 0;
    logic [17:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_gen_top dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .op_lo(op_lo),
        .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .pc(pc),
        .pen_ok(pen_ok), .br_taken(br_taken), .busy(busy), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .ea(ea),
        .extra_cyc(extra_cyc)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5C;
    endfunction

    always @(posedge clk) rd_data <= rd_req ? mem_byte(rd_addr) : 8'h00;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check("R9 done with no pending request", 32'd1, 32'd0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                check("R1-R8 ea value", {16'h0, ea}, {16'h0, e[17:2]});
                check("R3 R7 R8 extra cycles", {30'h0, extra_cyc}, {30'h0, e[1:0]});
            end
        end
    end

    // Driver: computes the expected result from the requirements
    task automatic issue(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y, input logic [15:0] p,
                         input logic pen, input logic tk, input logic poke);
        logic [15:0] e_ea, base, ptr, wrd, b1, tg;
        logic [1:0]  e_x;
        logic        ind;
        e_x = 2'd0;
        ind = 1'b0;
        ptr = 16'h0;
        case (m)
            4'd0: e_ea = {8'h00, lo};
            4'd1: e_ea = {8'h00, 8'(lo + x)};
            4'd2: e_ea = {8'h00, 8'(lo + y)};
            4'd3: e_ea = {hi, lo};
            4'd4, 4'd5: begin
                base = {hi, lo};
                e_ea = base + {8'h00, (m == 4'd4) ? x : y};
                e_x  = (pen && base[15:8] != e_ea[15:8]) ? 2'd1 : 2'd0;
            end
            4'd6, 4'd7: begin
                ind = 1'b1;
                ptr = {8'h00, (m == 4'd6) ? 8'(lo + x) : lo};
                wrd = {mem_byte(ptr + 16'd1), mem_byte(ptr)};
                if (m == 4'd6) e_ea = wrd;
                else begin
                    e_ea = wrd + {8'h00, y};
                    e_x  = (pen && wrd[15:8] != e_ea[15:8]) ? 2'd1 : 2'd0;
                end
            end
            default: begin
                b1 = p + 16'd1;
                tg = b1 + {{8{lo[7]}}, lo};
                if (tk) begin
                    e_ea = tg;
                    e_x  = (b1[15:8] != tg[15:8]) ? 2'd2 : 2'd1;
                end else e_ea = b1;
            end
        endcase
        @(negedge clk);
        mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y; pc = p;
        pen_ok = pen; br_taken = tk; start = 1'b1;
        exp_q.push_back({e_ea, e_x});
        @(negedge clk);
        start = 1'b0;
        if (!ind) begin
            check("R9 direct done latency", {31'h0, done}, 32'd1);
        end else begin
            check("R6 first read strobe", {31'h0, rd_req}, 32'd1);
            check("R6 low byte address", {16'h0, rd_addr}, {16'h0, ptr});
            if (poke) begin
                mode = 4'd0; op_lo = 8'h33; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            check("R6 high byte address", {16'h0, rd_addr}, {16'h0, ptr + 16'd1});
            @(negedge clk);
            check("R9 no done before pointer", {31'h0, done}, 32'd0);
            @(negedge clk);
            check("R9 indirect done latency", {31'h0, done}, 32'd1);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset done", {31'h0, done}, 32'd0);
        check("R10 reset busy", {31'h0, busy}, 32'd0);
        check("R10 reset rd_req", {31'h0, rd_req}, 32'd0);
        check("R10 reset ea", {16'h0, ea}, 32'd0);
        check("R10 reset extra", {30'h0, extra_cyc}, 32'd0);
        // R1 zero page variants and wrap
        issue(4'd0, 8'h42, 8'h99, 8'h10, 8'h20, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd1, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd2, 8'h80, 8'h12, 8'h00, 8'h85, 16'h0, 1'b1, 1'b0, 1'b0);
        // R2 R3 absolute forms
        issue(4'd3, 8'h34, 8'h12, 8'h55, 8'h66, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 16'h0, 1'b0, 1'b0, 1'b0);
        issue(4'd5, 8'h10, 8'h40, 8'h00, 8'h20, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd5, 8'hF0, 8'hFF, 8'h00, 8'h20, 16'h0, 1'b1, 1'b0, 1'b0);
        // R4 R5 R6 indirect forms
        issue(4'd6, 8'h80, 8'h00, 8'h10, 8'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd6, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd7, 8'h20, 8'h00, 8'h00, 8'h05, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd7, 8'h21, 8'h00, 8'h00, 8'hFF, 16'h0, 1'b1, 1'b0, 1'b0);
        issue(4'd7, 8'h21, 8'h00, 8'h00, 8'hFF, 16'h0, 1'b0, 1'b0, 1'b0);
        issue(4'd7, 8'hFF, 8'h00, 8'h00, 8'h01, 16'h0, 1'b1, 1'b0, 1'b0);
        // R9 start while busy is ignored
        issue(4'd6, 8'h40, 8'h00, 8'h02, 8'h00, 16'h0, 1'b1, 1'b0, 1'b1);
        // R7 R8 relative branches
        issue(4'd8, 8'h10, 8'h00, 8'h00, 8'h00, 16'h1230, 1'b0, 1'b1, 1'b0);
        issue(4'd8, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h1205, 1'b0, 1'b1, 1'b0);
        issue(4'd8, 8'h7F, 8'h00, 8'h00, 8'h00, 16'h12F0, 1'b0, 1'b1, 1'b0);
        issue(4'd8, 8'hF0, 8'h00, 8'h00, 8'h00, 16'h1205, 1'b0, 1'b0, 1'b0);
        issue(4'd8, 8'h05, 8'h00, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        check("R9 all results delivered", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule